// File: doc/BRIEF.md
# SPI Master with Command-Queued Framing

This block is an SPI master. Its transmit FIFO holds two kinds of entries: data words to shift out, and command words that set how later frames are shaped. A command word sets the frame length, whether chip select stays low between frames, and whether the transmit or receive side is masked. Commands share the FIFO with data, so each command acts only when the engine reaches it. All data queued before it has been shifted out by then. This lets software switch chip-select continuity or frame size exactly between two queued frames without waiting on the bus.

The engine drives SCK and MOSI in SPI mode 0, MSB first, and samples MISO into a receive FIFO. It controls one active-low chip select. Fixed delays, counted in SCK half-period ticks, separate chip-select assertion from the first edge, the last edge from negation, and one frame from the next. Status is reported by several separate flags, because "word shifted", "chip select released" and "queue drained" are different events for the host: word complete, frame complete, transfer complete, busy, transmit request and receive ready.

The host pushes words with `wr_en` and uses `wr_cmd` to say whether the word is a command or data. It pops received words with `rd_en`.

Top module: `spi_cmdq_master`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, `busy` is 0, `tx_req` is 1, `rx_rdy` is 0, and `wcf`, `fcf` and `tcf` are all 0.
- R2: Command bits [4:0] hold the frame length minus one (7 gives 8 bits). A data frame sends the low bits of the data word, MSB first. MOSI is stable on each rising SCK edge and changes after the falling edge. SCK rests low whenever `cs_n` is high.
- R3: A command word takes effect only after every data word queued before it has been shifted out.
- R4: When command bit 8 (hold) is set, `cs_n` stays low after a frame ends and the next frames follow without re-selecting. A later command with bit 8 clear makes `cs_n` return high.
- R5: With command bit 10 (transmit mask) set, the command alone starts one frame with MOSI held low. The mask then clears itself, so the next data word is sent normally.
- R6: `wcf` sets when the last bit of each word has been shifted, and this happens even when receive is masked.
- R7: `fcf` sets when `cs_n` returns high at the end of a frame. It stays clear while chip select is held between frames.
- R8: `tcf` sets when the engine returns to idle with chip select released and the transmit FIFO empty. It stays clear while chip select is held.
- R9: `tx_req` is 1 while the transmit FIFO count is at or below TX_WM. `rx_rdy` is 1 while the receive FIFO count is above RX_WM.
- R10: `busy` is 1 from chip-select assertion until the end of the inter-frame gap, and it stays 1 while chip select is held. When `busy` is 0, `cs_n` is 1.
- R11: Writing 1 to a bit of `flag_clr` clears the matching flag: bit 0 clears `wcf`, bit 1 clears `fcf`, bit 2 clears `tcf`. Other flags are left as they are.
- R12: With command bit 9 (receive mask) set, received words are dropped and the receive FIFO is not written.
- R13: A received word is stored right-justified, holding the MISO bits of the frame in arrival order with the first bit as the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Push `wr_word` into the transmit FIFO |
| wr_cmd | input | 1 | 1: pushed word is a command, 0: data |
| wr_word | input | 32 | Data or command word |
| rd_en | input | 1 | Pop the receive FIFO |
| rd_word | output | 32 | Head of the receive FIFO |
| flag_clr | input | 3 | Write-1-to-clear for wcf, fcf, tcf |
| wcf | output | 1 | Word complete flag |
| fcf | output | 1 | Frame complete flag |
| tcf | output | 1 | Transfer complete flag |
| busy | output | 1 | Bus transfer in progress |
| tx_req | output | 1 | Transmit FIFO at or below watermark |
| rx_rdy | output | 1 | Receive FIFO above watermark |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The event flags are registered on the same edge as their event. `wcf` sets on the clock edge that drives the last falling SCK edge of a word. `fcf` sets on the edge where `cs_n` rises, and `tcf` sets on the edge that ends the gap. A received word is at the receive FIFO head one cycle after its word-complete edge. `tx_req` and `rx_rdy` follow the FIFO counts one cycle after a push or pop. The bench does not count bus cycles itself. It waits for `tcf` and then samples every output at the following falling clock edge, when all of these results have already settled. The mid-transfer hold check is sampled well after both frames must have finished.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned FS_W   = 5;

  typedef struct packed {
    logic            txmask;
    logic            rxmask;
    logic            hold;
    logic [FS_W-1:0] fs;
  } spim_cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_SHIFT, ST_LAG, ST_GAP
  } spim_state_t;

  // Command word fields: [10] tx mask, [9] rx mask, [8] hold, [4:0] bits-1
  function automatic spim_cmd_t spim_decode(input logic [WORD_W-1:0] w);
    spim_cmd_t c;
    c.txmask = w[10];
    c.rxmask = w[9];
    c.hold   = w[8];
    c.fs     = w[FS_W-1:0];
    return c;
  endfunction

  // Ones in bit positions 0..fs
  function automatic logic [WORD_W-1:0] spim_frame_mask(input logic [FS_W-1:0] fs);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < WORD_W; i++) m[i] = (i <= int'(fs));
    return m;
  endfunction
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign do_push = push && (count != CW'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int SCK_DIV = 2,
  parameter int LEAD_T  = 2,
  parameter int LAG_T   = 2,
  parameter int GAP_T   = 2,
  localparam int DIV_W  = $clog2(SCK_DIV) + 1,
  localparam int DLY_W  = $clog2(LEAD_T + LAG_T + GAP_T + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_vld,
  input  logic              head_cmd,
  input  logic [WORD_W-1:0] head_word,
  output logic              pop,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              cs_n,
  output logic              word_done,
  output logic              frame_done,
  output logic              xfer_done,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_word,
  output logic              busy,
  output logic              act_rxmask
);
  spim_state_t       state;
  spim_cmd_t         cmd_r, hd;
  logic [WORD_W-1:0] tx_sh, rx_sh;
  logic [FS_W-1:0]   bit_cnt;
  logic [DLY_W-1:0]  dly;
  logic [DIV_W-1:0]  div_cnt;
  logic              ph, tick, go_frame, go_lag, last_bit;

  assign tick     = (div_cnt == DIV_W'(SCK_DIV - 1));
  assign hd       = spim_decode(head_word);
  assign pop      = (state == ST_IDLE) && head_vld;
  assign go_frame = pop && (!head_cmd || hd.txmask);
  assign go_lag   = pop && head_cmd && !hd.txmask && !hd.hold && !cs_n;
  assign last_bit = (bit_cnt == cmd_r.fs);

  assign word_done  = (state == ST_SHIFT) && tick && ph && last_bit;
  assign frame_done = (state == ST_LAG) && tick && (dly == DLY_W'(LAG_T - 1));
  assign xfer_done  = (state == ST_GAP) && tick && (dly == DLY_W'(GAP_T - 1)) && !head_vld;
  assign rx_push    = word_done && !cmd_r.rxmask;
  assign rx_word    = rx_sh & spim_frame_mask(cmd_r.fs);
  assign busy       = (state != ST_IDLE) || !cs_n;
  assign mosi       = !cs_n && tx_sh[cmd_r.fs];
  assign act_rxmask = cmd_r.rxmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cmd_r   <= '{txmask: 1'b0, rxmask: 1'b0, hold: 1'b0, fs: FS_W'(7)};
      cs_n    <= 1'b1;
      sck     <= 1'b0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      bit_cnt <= '0;
      dly     <= '0;
      ph      <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (pop && head_cmd) cmd_r <= hd;
          if (go_frame) begin
            tx_sh   <= head_cmd ? '0 : head_word;
            rx_sh   <= '0;
            bit_cnt <= '0;
            ph      <= 1'b0;
            dly     <= '0;
            if (cs_n) begin
              cs_n  <= 1'b0;
              state <= ST_LEAD;
            end else begin
              state <= ST_SHIFT;
            end
          end else if (go_lag) begin
            dly   <= '0;
            state <= ST_LAG;
          end
        end
        ST_LEAD: if (tick) begin
          if (dly == DLY_W'(LEAD_T - 1)) begin
            dly   <= '0;
            state <= ST_SHIFT;
          end else dly <= dly + DLY_W'(1);
        end
        ST_SHIFT: if (tick) begin
          if (!ph) begin
            sck   <= 1'b1;
            rx_sh <= {rx_sh[WORD_W-2:0], miso};
            ph    <= 1'b1;
          end else begin
            sck <= 1'b0;
            ph  <= 1'b0;
            if (last_bit) begin
              cmd_r.txmask <= 1'b0;
              dly          <= '0;
              state        <= cmd_r.hold ? ST_IDLE : ST_LAG;
            end else begin
              bit_cnt <= bit_cnt + FS_W'(1);
              tx_sh   <= tx_sh << 1;
            end
          end
        end
        ST_LAG: if (tick) begin
          if (frame_done) begin
            cs_n  <= 1'b1;
            dly   <= '0;
            state <= ST_GAP;
          end else dly <= dly + DLY_W'(1);
        end
        ST_GAP: if (tick) begin
          if (dly == DLY_W'(GAP_T - 1)) state <= ST_IDLE;
          else                          dly   <= dly + DLY_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmdq_master.sv
module spi_cmdq_master
  import spim_pkg::*;
#(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int TX_WM    = 1,
  parameter int RX_WM    = 0,
  parameter int SCK_DIV  = 2,
  parameter int LEAD_T   = 2,
  parameter int LAG_T    = 2,
  parameter int GAP_T    = 2,
  localparam int TCW     = $clog2(TX_DEPTH + 1),
  localparam int RCW     = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_cmd,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_word,
  input  logic [2:0]        flag_clr,
  output logic              wcf,
  output logic              fcf,
  output logic              tcf,
  output logic              busy,
  output logic              tx_req,
  output logic              rx_rdy,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  logic [WORD_W:0]   tx_head;
  logic [TCW-1:0]    tx_cnt;
  logic [RCW-1:0]    rx_cnt;
  logic              tx_pop, ev_word, ev_frame, ev_xfer, ev_rxpush, eng_rxmask;
  logic [WORD_W-1:0] rx_word;

  spim_fifo #(.W(WORD_W + 1), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .pop(tx_pop),
    .din({wr_cmd, wr_word}), .dout(tx_head), .count(tx_cnt)
  );

  spim_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(ev_rxpush), .pop(rd_en),
    .din(rx_word), .dout(rd_word), .count(rx_cnt)
  );

  spim_engine #(.SCK_DIV(SCK_DIV), .LEAD_T(LEAD_T), .LAG_T(LAG_T), .GAP_T(GAP_T)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .head_vld(tx_cnt != '0), .head_cmd(tx_head[WORD_W]), .head_word(tx_head[WORD_W-1:0]),
    .pop(tx_pop), .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n),
    .word_done(ev_word), .frame_done(ev_frame), .xfer_done(ev_xfer),
    .rx_push(ev_rxpush), .rx_word(rx_word), .busy(busy), .act_rxmask(eng_rxmask)
  );

  assign tx_req = (tx_cnt <= TCW'(TX_WM));
  assign rx_rdy = (rx_cnt > RCW'(RX_WM));

  // Sticky flags; a new event wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcf <= 1'b0;
      fcf <= 1'b0;
      tcf <= 1'b0;
    end else begin
      wcf <= ev_word  | (wcf & ~flag_clr[0]);
      fcf <= ev_frame | (fcf & ~flag_clr[1]);
      tcf <= ev_xfer  | (tcf & ~flag_clr[2]);
    end
  end
endmodule

// File: rtl/spim_sva.sv
module spim_sva #(parameter int CW = 3) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          sck,
  input logic          busy,
  input logic          wcf,
  input logic          fcf,
  input logic          ev_word,
  input logic          eng_rxmask,
  input logic          rd_en,
  input logic [CW-1:0] rx_cnt
);
  AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n); // R10
  AST_SCK_REST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck); // R2
  AST_FCF_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> fcf); // R7
  AST_WCF_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_word |=> wcf); // R6
  AST_RXMASK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_word && eng_rxmask && !rd_en) |=> (rx_cnt == $past(rx_cnt))); // R12
endmodule

bind spi_cmdq_master spim_sva #(.CW(RCW)) u_sva (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .busy(busy),
  .wcf(wcf), .fcf(fcf), .ev_word(ev_word), .eng_rxmask(eng_rxmask),
  .rd_en(rd_en), .rx_cnt(rx_cnt)
);

// File: tb/test_spi_cmdq_master.sv
module test_spi_cmdq_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_cmd = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_word = '0;
  logic [2:0]  flag_clr = '0;
  logic [31:0] rd_word;
  logic        wcf, fcf, tcf, busy, tx_req, rx_rdy, sck, mosi, miso, cs_n;

  always #5 clk = ~clk;

  spi_cmdq_master i_spi_cmdq_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_word(wr_word),
    .rd_en(rd_en), .rd_word(rd_word), .flag_clr(flag_clr), .wcf(wcf), .fcf(fcf),
    .tcf(tcf), .busy(busy), .tx_req(tx_req), .rx_rdy(rx_rdy), .sck(sck),
    .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int n_chk = 0, n_bad = 0;

  // Slave model: replays PAT from its MSB after each select, shifting on falling SCK
  localparam logic [31:0] PAT = 32'hC95EA713;
  int          n_csf = 0, n_sckf = 0, snap = 0, n_bits = 0;
  logic [63:0] mlog = '0;
  always @(negedge cs_n) begin n_csf++; snap = n_sckf; end
  always @(negedge sck) n_sckf++;
  always @(posedge sck) begin mlog = {mlog[62:0], mosi}; n_bits++; end
  assign miso = PAT[5'(31 - ((n_sckf - snap) % 32))];

  function automatic logic [31:0] cmdw(input int fs, input bit hold, input bit rxm, input bit txm);
    return {21'b0, txm, rxm, hold, 3'b0, 5'(fs)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input bit is_cmd, input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_cmd = is_cmd; wr_word = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_flags(input logic [2:0] m);
    @(negedge clk); flag_clr = m;
    @(negedge clk); flag_clr = '0;
  endtask

  task automatic wait_tcf(input string req);
    int k = 0;
    while (tcf !== 1'b1 && k < 3000) begin @(negedge clk); k++; end
    if (tcf !== 1'b1) begin
      n_chk++; n_bad++;
      $display("FAIL %s actual=tcf_timeout expected=tcf_set", req);
    end
  endtask

  task automatic pop_rx(input string req, input logic [31:0] exp);
    @(negedge clk);
    check({req, " rx_rdy"}, rx_rdy, 1'b1);
    check({req, " rx word"}, rd_word, exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 cs_n", cs_n, 1'b1);
    check("R1 sck", sck, 1'b0);
    check("R1 busy", busy, 1'b0);
    check("R1 tx_req", tx_req, 1'b1);
    check("R1 rx_rdy", rx_rdy, 1'b0);
    check("R1 flags", {wcf, fcf, tcf}, 3'b000);
  endtask

  task automatic t_basic;
    int b0 = n_bits, c0 = n_csf;
    push(1'b1, cmdw(7, 0, 0, 0));
    push(1'b0, 32'h0000_00A5);
    wait_tcf("R8 basic");
    @(negedge clk);
    check("R2 8-bit count", n_bits - b0, 8);
    check("R2 mosi byte", mlog[7:0], 8'hA5);
    check("R2 one select", n_csf - c0, 1);
    check("R6 wcf", wcf, 1'b1);
    check("R7 fcf", fcf, 1'b1);
    check("R8 tcf", tcf, 1'b1);
    check("R10 busy idle", busy, 1'b0);
    pop_rx("R13 basic", 32'h0000_00C9);
  endtask

  task automatic t_w1c;
    clear_flags(3'b001);
    @(negedge clk);
    check("R11 wcf cleared", wcf, 1'b0);
    check("R11 fcf kept", fcf, 1'b1);
    check("R11 tcf kept", tcf, 1'b1);
    clear_flags(3'b110);
    @(negedge clk);
    check("R11 all clear", {wcf, fcf, tcf}, 3'b000);
  endtask

  task automatic t_frame16;
    int b0 = n_bits;
    push(1'b1, cmdw(15, 0, 0, 0));
    push(1'b0, 32'h1234_BEEF);
    wait_tcf("R2 16-bit");
    @(negedge clk);
    check("R2 16-bit count", n_bits - b0, 16);
    check("R2 16-bit data", mlog[15:0], 16'hBEEF);
    pop_rx("R13 16-bit", 32'h0000_C95E);
    clear_flags(3'b111);
  endtask

  task automatic t_order;
    int b0 = n_bits, c0 = n_csf;
    push(1'b1, cmdw(7, 0, 0, 0));
    push(1'b0, 32'hFFFF_FF11);
    push(1'b1, cmdw(11, 0, 0, 0));
    push(1'b0, 32'h0000_0ABC);
    wait_tcf("R3 order");
    @(negedge clk);
    check("R3 total bits", n_bits - b0, 20);
    check("R3 bit stream", mlog[19:0], 20'h11ABC);
    check("R3 selects", n_csf - c0, 2);
    pop_rx("R3 first rx", 32'h0000_00C9);
    pop_rx("R13 12-bit rx", 32'h0000_0C95);
    clear_flags(3'b111);
  endtask

  task automatic t_hold;
    int b0 = n_bits, c0 = n_csf;
    push(1'b1, cmdw(7, 1, 0, 0));
    push(1'b0, 32'h0000_003C);
    push(1'b0, 32'h0000_00C3);
    repeat (300) @(negedge clk);
    check("R4 cs held", cs_n, 1'b0);
    check("R10 busy while held", busy, 1'b1);
    check("R7 no fcf while held", fcf, 1'b0);
    check("R8 no tcf while held", tcf, 1'b0);
    check("R6 wcf in hold", wcf, 1'b1);
    check("R4 bits", n_bits - b0, 16);
    check("R4 data", mlog[15:0], 16'h3CC3);
    push(1'b1, cmdw(7, 0, 0, 0));
    wait_tcf("R4 release");
    @(negedge clk);
    check("R4 cs released", cs_n, 1'b1);
    check("R7 fcf on release", fcf, 1'b1);
    check("R4 single select", n_csf - c0, 1);
    pop_rx("R4 rx0", 32'h0000_00C9);
    pop_rx("R4 rx1", 32'h0000_005E);
    clear_flags(3'b111);
  endtask

  task automatic t_txmask;
    int b0 = n_bits;
    push(1'b1, cmdw(7, 0, 0, 1));
    wait_tcf("R5 masked frame");
    @(negedge clk);
    check("R5 masked bits", n_bits - b0, 8);
    check("R5 mosi low", mlog[7:0], 8'h00);
    pop_rx("R5 rx", 32'h0000_00C9);
    clear_flags(3'b111);
    b0 = n_bits;
    push(1'b0, 32'h0000_005A);
    wait_tcf("R5 after mask");
    @(negedge clk);
    check("R5 mask cleared bits", n_bits - b0, 8);
    check("R5 mask cleared data", mlog[7:0], 8'h5A);
    pop_rx("R5 rx2", 32'h0000_00C9);
    clear_flags(3'b111);
  endtask

  task automatic t_rxmask;
    push(1'b1, cmdw(7, 0, 1, 0));
    push(1'b0, 32'h0000_0077);
    wait_tcf("R12 rx masked");
    @(negedge clk);
    check("R6 wcf with rx mask", wcf, 1'b1);
    check("R12 rx fifo empty", rx_rdy, 1'b0);
    check("R12 data still sent", mlog[7:0], 8'h77);
    clear_flags(3'b111);
  endtask

  task automatic t_watermark;
    push(1'b1, cmdw(7, 0, 0, 0));
    repeat (5) @(negedge clk);
    for (int i = 1; i <= 4; i++) begin
      wr_en = 1'b1; wr_cmd = 1'b0; wr_word = 32'(i);
      @(negedge clk);
    end
    wr_en = 1'b0;
    check("R9 tx_req low above wm", tx_req, 1'b0);
    wait_tcf("R9 drain");
    @(negedge clk);
    check("R9 tx_req high", tx_req, 1'b1);
    check("R9 stream", mlog[31:0], 32'h0102_0304);
    for (int i = 0; i < 4; i++) pop_rx("R9 rx", 32'h0000_00C9);
    @(negedge clk);
    check("R9 rx_rdy low", rx_rdy, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_w1c();
    t_frame16();
    t_order();
    t_hold();
    t_txmask();
    t_rxmask();
    t_watermark();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule